// File: doc/BRIEF.md
# Register-Mapped Integer Square Root Unit

This peripheral computes the floor of the square root of an unsigned operand written by software over a small 32-bit register bus. The operand is held in two 32-bit parameter words. A control bit selects whether only the low word is used (narrow mode) or both words form a 64-bit value (wide mode). The root is always a 32-bit unsigned value.

Any write to a parameter word or to the control register starts a new computation, and a computation already in progress is abandoned. The engine first aligns a trial bit to the highest even bit position, taken as a power of four, that does not exceed the operand. It does this in a single load cycle. It then retires one root bit per clock with the shift-by-two bit-pair method. A busy flag in the control register stays set from the write until the root register holds the new value. Software polls this flag and then reads the root.

Top module: `sqrt_unit`

## Requirements
- R1: After reset the control word reads 0 (busy clear, narrow mode), both parameter words read 0 and the root register reads 0.
- R2: With control bit 0 clear, the operand is the low parameter word only. The high parameter word has no effect on the root.
- R3: With control bit 0 set, the operand is {high word, low word} as one 64-bit unsigned value.
- R4: When busy clears, the root register holds r with r*r <= operand < (r+1)*(r+1).
- R5: A write to word address 0 (control), 1 (parameter low) or 2 (parameter high) makes busy (control bit 15) read 1 from the next clock edge on.
- R6: Busy stays set for at most 33 clock cycles after the edge that takes the last write.
- R7: An operand of zero gives a root of zero.
- R8: A write that arrives while busy restarts the computation, and the root that appears is that of the latest operand.
- R9: Word address 3 is the read-only root register. A write to it changes neither the root nor busy.
- R10: The parameter words read back as written, and control bit 0 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 control, 1 parameter low, 2 parameter high, 3 root |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |

## Verification
The bench sends random operands in both modes. In narrow mode the high word is filled with junk, so a design that fails to mask it gives a wrong root. In wide mode the high word is non-zero, so a design that drops it also gives a wrong root. Directed cases cover zero, one, perfect squares and their neighbours, and the all-ones 64-bit value. Between them these cases separate off-by-one alignment errors from faults in the compare and subtract steps. A restart in mid-computation shows whether a stale operand can leak into the result. Each root is checked against a reference built by bitwise binary search.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
    localparam int BUS_W  = 32;
    localparam int OPER_W = 2 * BUS_W;
    localparam int ROOT_W = OPER_W / 2;
    localparam int ADDR_W = 2;
    localparam int BUSY_BIT = 15;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_ROOT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [OPER_W-1:0] rem;
        logic [OPER_W-1:0] acc;
        logic [OPER_W-1:0] trial;
    } sqrt_state_t;

    // highest power of four not exceeding x (zero when x is zero)
    function automatic logic [OPER_W-1:0] first_trial(input logic [OPER_W-1:0] x);
        logic [OPER_W-1:0] t;
        t = '0;
        for (int i = 0; i < OPER_W / 2; i++) begin
            if (x[2*i] || x[2*i+1]) t = {{(OPER_W-1){1'b0}}, 1'b1} << (2 * i);
        end
        return t;
    endfunction
endpackage

// File: rtl/sqrt_regs.sv
module sqrt_regs
    import sqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic              wide_q,
    output logic [BUS_W-1:0]  p_lo,
    output logic [BUS_W-1:0]  p_hi,
    output logic              go_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q <= 1'b0;
            p_lo   <= '0;
            p_hi   <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (wr_en) begin
                case (sel)
                    SEL_CTRL: begin wide_q <= wdata[0]; go_q <= 1'b1; end
                    SEL_PLO:  begin p_lo   <= wdata;    go_q <= 1'b1; end
                    SEL_PHI:  begin p_hi   <= wdata;    go_q <= 1'b1; end
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sqrt_core.sv
module sqrt_core
    import sqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [OPER_W-1:0] operand,
    output logic              running,
    output logic [ROOT_W-1:0] root
);
    sqrt_state_t st, nxt;
    logic [OPER_W-1:0] sum;

    always_comb begin
        sum       = st.acc + st.trial;
        nxt.trial = st.trial >> 2;
        if (st.rem >= sum) begin
            nxt.rem = st.rem - sum;
            nxt.acc = (st.acc >> 1) + st.trial;
        end else begin
            nxt.rem = st.rem;
            nxt.acc = st.acc >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            running <= 1'b0;
            root    <= '0;
        end else if (go) begin
            st.rem   <= operand;
            st.acc   <= '0;
            st.trial <= first_trial(operand);
            if (operand == '0) begin
                root    <= '0;
                running <= 1'b0;
            end else begin
                running <= 1'b1;
            end
        end else if (running) begin
            st <= nxt;
            if (nxt.trial == '0) begin
                root    <= nxt.acc[ROOT_W-1:0];
                running <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sqrt_unit.sv
module sqrt_unit
    import sqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    logic              wide_q, go_q, running, busy;
    logic [BUS_W-1:0]  p_lo, p_hi;
    logic [OPER_W-1:0] operand;
    logic [ROOT_W-1:0] root;

    sqrt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wide_q(wide_q), .p_lo(p_lo), .p_hi(p_hi), .go_q(go_q)
    );

    assign operand = wide_q ? {p_hi, p_lo} : {{BUS_W{1'b0}}, p_lo};

    sqrt_core u_core (
        .clk(clk), .rst(rst), .go(go_q), .operand(operand),
        .running(running), .root(root)
    );

    assign busy = go_q | running;

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            SEL_CTRL: begin rdata[0] = wide_q; rdata[BUSY_BIT] = busy; end
            SEL_PLO:  rdata = p_lo;
            SEL_PHI:  rdata = p_hi;
            default:  rdata = root;
        endcase
    end
endmodule

// File: rtl/sqrt_unit_chk.sv
module sqrt_unit_chk
    import sqrt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic              busy,
    input logic              wide,
    input logic [BUS_W-1:0]  p_lo,
    input logic [BUS_W-1:0]  p_hi,
    input logic [ROOT_W-1:0] root
);
    logic [5:0]  busy_cnt;
    logic [OPER_W+1:0] x, r2, r1sq;

    assign x    = {2'b00, (wide ? {p_hi, p_lo} : {{BUS_W{1'b0}}, p_lo})};
    assign r2   = {34'd0, root} * {34'd0, root};
    assign r1sq = ({34'd0, root} + 1) * ({34'd0, root} + 1);

    always_ff @(posedge clk) begin
        if (rst) busy_cnt <= '0;
        else if (wr_en && addr != 2'd3) busy_cnt <= '0;
        else if (busy && busy_cnt != 6'h3f) busy_cnt <= busy_cnt + 1'b1;
        else if (!busy) busy_cnt <= '0;
    end

    assert_busy_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != 2'd3) |=> busy);
    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= 6'd33);
    assert_root_floor_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (r2 <= x && r1sq > x));
    assert_zero_root_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && x == '0) |-> root == '0);
    assert_root_held_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(root));
endmodule

bind sqrt_unit sqrt_unit_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .busy(busy),
    .wide(wide_q), .p_lo(p_lo), .p_hi(p_hi), .root(root)
);

// File: tb/sqrt_unit_bench.sv
module sqrt_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sqrt_unit u_sqrt_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] ref_root(input logic [63:0] x);
        logic [31:0] r;
        logic [31:0] c;
        r = '0;
        for (int b = 31; b >= 0; b--) begin
            c = r | (32'd1 << b);
            if ({32'd0, c} * {32'd0, c} <= x) r = c;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // returns cycles spent busy after the write edge
    task automatic wait_done(output int cyc);
        logic [31:0] v;
        cyc = 0;
        rd(2'd0, v);
        while (v[15] && cyc < 60) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            rd(2'd0, v);
        end
    endtask

    task automatic run_case(input string req, input bit wide, input logic [63:0] val);
        logic [31:0] v;
        logic [63:0] x;
        int cyc;
        wr(2'd1, val[31:0]);
        wr(2'd2, val[63:32]);
        wr(2'd0, {31'd0, wide});
        rd(2'd0, v);
        check("R5 busy after write", {31'd0, v[15]}, 32'd1);
        wait_done(cyc);
        check("R6 busy within 33 cycles", {31'd0, (cyc <= 33)}, 32'd1);
        x = wide ? val : {32'd0, val[31:0]};
        rd(2'd3, v);
        check(req, v, ref_root(x));
    endtask

    initial begin
        logic [31:0] v;
        int cyc;
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 32'd0);
        rd(2'd1, v); check("R1 plo", v, 32'd0);
        rd(2'd2, v); check("R1 phi", v, 32'd0);
        rd(2'd3, v); check("R1 root", v, 32'd0);
        // R9 write to root ignored
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, v); check("R9 root unchanged", v, 32'd0);
        rd(2'd0, v); check("R9 no busy", {31'd0, v[15]}, 32'd0);
        // R10 readback
        wr(2'd1, 32'h1234_5678); wr(2'd2, 32'h9ABC_DEF0); wr(2'd0, 32'd1);
        rd(2'd1, v); check("R10 plo", v, 32'h1234_5678);
        rd(2'd2, v); check("R10 phi", v, 32'h9ABC_DEF0);
        rd(2'd0, v); check("R10 wide bit", {31'd0, v[0]}, 32'd1);
        wait_done(cyc);
        // R7 zero
        run_case("R7 zero narrow", 1'b0, 64'hFFFF_FFFF_0000_0000);
        run_case("R7 zero wide", 1'b1, 64'd0);
        // R2 masking: junk high word
        run_case("R2 narrow masks high", 1'b0, 64'hFFFF_FFFF_0000_0010);
        run_case("R2 narrow max", 1'b0, 64'hA5A5_A5A5_FFFF_FFFF);
        // R3 wide
        run_case("R3 wide all ones", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        run_case("R3 wide 2^32", 1'b1, 64'h0000_0001_0000_0000);
        run_case("R3 wide high bit", 1'b1, 64'h8000_0000_0000_0000);
        // R4 corners
        run_case("R4 one", 1'b0, 64'd1);
        run_case("R4 three", 1'b0, 64'd3);
        run_case("R4 square", 1'b0, 64'd144);
        run_case("R4 square minus one", 1'b0, 64'd143);
        run_case("R4 wide square", 1'b1, 64'hFFFF_FFFE_0000_0001);
        for (int i = 0; i < 40; i++) begin
            logic [63:0] rv;
            rv = {$urandom, $urandom};
            run_case("R2 R4 random narrow", 1'b0, rv);
            rv = {$urandom >> ($urandom % 32), $urandom};
            run_case("R3 R4 random wide", 1'b1, rv);
        end
        // R8 restart mid-computation
        wr(2'd0, 32'd0);
        wait_done(cyc);
        wr(2'd1, 32'hFFFF_0000);
        @(negedge clk); @(negedge clk);
        rd(2'd0, v); check("R8 still busy", {31'd0, v[15]}, 32'd1);
        wr(2'd1, 32'd49);
        wait_done(cyc);
        rd(2'd3, v); check("R8 latest operand", v, 32'd7);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule